// File: doc/BRIEF.md
# Search Branch Step Unit

This block carries out a single decision step of a bus device-address search. Once started, it runs two read time slots on the shared bus. The first read returns the address bit at the current tree position. The second returns that bit's inverse. From those two values the unit picks which branch to follow and then runs one write time slot that carries the chosen bit, so that devices on the other branch drop out. If no device answers, both reads come back as 1. In that case the step is abandoned and no write slot is run.

The unit does not drive the bus wire itself. It asks a separate bit-timing engine for slots over a request/acknowledge port: a request, a slot kind, and the bit to send on a write. The engine acknowledges each slot and returns the sampled level for reads. The caller pulses `start` and gives a preferred bit to use when devices on the bus disagree. It then waits for `done` and reads a 3-bit status. Walking the whole address tree across many steps is left to the caller.

Top module: `trip_search_step`

## Requirements
- R1: While reset is asserted and after it is released, `status` is 0, `done` is 0, `busy` is 0 and `slot_req` is 0.
- R2: A `start` pulse seen while `busy` is 0 is accepted. On the next cycle `busy` is 1 and `status` is cleared to 0. `pref_dir` is captured in that same cycle.
- R3: Slots are requested one at a time. A request stays raised with a fixed kind and write bit until `slot_ack` is seen. The first two slots of every step are reads (`slot_kind` = 0): the first samples the address bit and the second samples its complement.
- R4: Status bit 0 holds the sampled address bit, bit 1 holds the sampled complement, and bit 2 holds the direction taken.
- R5: When both sampled bits are 1, the step ends right after the second read with status 3. No write slot is requested.
- R6: When both sampled bits are 0, the unit writes the captured preferred bit and reports it in status bit 2. The result is status 4 for a preferred 1 and status 0 for a preferred 0.
- R7: When exactly one sampled bit is 1, the unit follows the address bit. It writes that bit and returns status 5 when the address bit is 1, or status 2 when it is 0.
- R8: A step that does not abort ends with exactly one write slot (`slot_kind` = 1) carrying the chosen direction. `done` rises on the cycle after that slot's acknowledge, and `busy` is 0 from then on.
- R9: `done` is high for exactly one cycle. `status` then keeps its value until the next accepted start.
- R10: A `start` pulse that arrives while `busy` is 1 has no effect on the slot sequence or on the result.
- R11: Changes to `pref_dir` after a start has been accepted do not change the direction written or reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one search step (ignored while busy) |
| pref_dir | input | 1 | Bit to write when devices disagree |
| slot_req | output | 1 | Slot request to the bit-timing engine |
| slot_kind | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Slot finished (one cycle) |
| slot_rbit | input | 1 | Level sampled during a read slot, valid with `slot_ack` |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle end-of-step strobe |
| status | output | 3 | {direction, complement bit, address bit} |

## Verification
The checks assume that the bit-timing engine raises `slot_ack` only while a request is pending, and only for one cycle per slot. They also assume that `slot_rbit` is valid in the cycle of the acknowledge. One checker property enforces this contract on the inputs. The bench's engine model keeps within it by answering a request only after it has seen that request at a falling edge. It waits 0 to 2 extra cycles before answering and then drops the acknowledge on the next cycle. Stray `start` pulses and `pref_dir` changes are driven only on falling edges, both while a step is running and while the unit is idle.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int STAT_W    = 3;
  localparam int ST_ID     = 0;
  localparam int ST_CMP    = 1;
  localparam int ST_DIR    = 2;
  localparam logic SLOT_READ  = 1'b0;
  localparam logic SLOT_WRITE = 1'b1;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_RD_ID  = 2'd1,
    S_RD_CMP = 2'd2,
    S_WR     = 2'd3
  } trip_state_e;

  // True when no device answered: both address bit and complement read high.
  function automatic logic trip_abort(input logic id_bit, input logic cmp_bit);
    return id_bit & cmp_bit;
  endfunction

  // Direction to follow: preferred bit when devices disagree, else the address bit.
  function automatic logic trip_dir(input logic id_bit, input logic cmp_bit,
                                    input logic pref);
    if (!id_bit && !cmp_bit) return pref;
    return id_bit;
  endfunction

  // Packed status word.
  function automatic logic [STAT_W-1:0] trip_code(input logic id_bit,
                                                  input logic cmp_bit,
                                                  input logic pref);
    logic [STAT_W-1:0] c;
    c         = '0;
    c[ST_ID]  = id_bit;
    c[ST_CMP] = cmp_bit;
    c[ST_DIR] = trip_abort(id_bit, cmp_bit) ? 1'b0 : trip_dir(id_bit, cmp_bit, pref);
    return c;
  endfunction
endpackage

// File: rtl/trip_decide.sv
module trip_decide
  import trip_pkg::*;
(
  input  logic              id_bit,
  input  logic              cmp_bit,
  input  logic              pref,
  output logic              abort,
  output logic              dir,
  output logic [STAT_W-1:0] code
);
  always_comb begin
    abort = trip_abort(id_bit, cmp_bit);
    dir   = trip_dir(id_bit, cmp_bit, pref);
    code  = trip_code(id_bit, cmp_bit, pref);
  end
endmodule

// File: rtl/trip_seq.sv
module trip_seq
  import trip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pref_dir,
  input  logic slot_ack,
  input  logic slot_rbit,
  input  logic abort_now,
  input  logic dir_now,
  output logic slot_req,
  output logic slot_kind,
  output logic slot_wbit,
  output logic busy,
  output logic id_q,
  output logic cmp_now,
  output logic pref_q,
  output logic ev_start,
  output logic ev_abort,
  output logic ev_wr_ack
);
  trip_state_e state_q, state_d;
  logic        cmp_q;
  logic        ev_id_ack, ev_cmp_ack;

  assign busy       = (state_q != S_IDLE);
  assign ev_start   = start && (state_q == S_IDLE);
  assign ev_id_ack  = (state_q == S_RD_ID)  && slot_ack;
  assign ev_cmp_ack = (state_q == S_RD_CMP) && slot_ack;
  assign ev_abort   = ev_cmp_ack && abort_now;
  assign ev_wr_ack  = (state_q == S_WR) && slot_ack;

  // Complement seen by the decision logic: live sample during its slot.
  assign cmp_now    = (state_q == S_RD_CMP) ? slot_rbit : cmp_q;

  assign slot_req   = busy;
  assign slot_kind  = (state_q == S_WR) ? SLOT_WRITE : SLOT_READ;
  assign slot_wbit  = (state_q == S_WR) ? dir_now : 1'b0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start)      state_d = S_RD_ID;
      S_RD_ID:  if (slot_ack)   state_d = S_RD_CMP;
      S_RD_CMP: if (slot_ack)   state_d = abort_now ? S_IDLE : S_WR;
      S_WR:     if (slot_ack)   state_d = S_IDLE;
      default:                  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      id_q    <= 1'b0;
      cmp_q   <= 1'b0;
      pref_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        pref_q <= pref_dir;
        id_q   <= 1'b0;
        cmp_q  <= 1'b0;
      end
      if (ev_id_ack)  id_q  <= slot_rbit;
      if (ev_cmp_ack) cmp_q <= slot_rbit;
    end
  end
endmodule

// File: rtl/trip_result.sv
module trip_result
  import trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_abort,
  input  logic              ev_wr_ack,
  input  logic [STAT_W-1:0] code,
  output logic [STAT_W-1:0] status,
  output logic              done
);
  logic finish;
  assign finish = ev_abort || ev_wr_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish)        status <= code;
      else if (ev_start) status <= '0;
    end
  end
endmodule

// File: rtl/trip_search_step.sv
module trip_search_step
  import trip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  output logic              slot_req,
  output logic              slot_kind,
  output logic              slot_wbit,
  input  logic              slot_ack,
  input  logic              slot_rbit,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] status
);
  logic              id_q, cmp_now, pref_q;
  logic              abort_now, dir_now;
  logic [STAT_W-1:0] code_now;
  logic              ev_start, ev_abort, ev_wr_ack;

  trip_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pref_dir  (pref_dir),
    .slot_ack  (slot_ack),
    .slot_rbit (slot_rbit),
    .abort_now (abort_now),
    .dir_now   (dir_now),
    .slot_req  (slot_req),
    .slot_kind (slot_kind),
    .slot_wbit (slot_wbit),
    .busy      (busy),
    .id_q      (id_q),
    .cmp_now   (cmp_now),
    .pref_q    (pref_q),
    .ev_start  (ev_start),
    .ev_abort  (ev_abort),
    .ev_wr_ack (ev_wr_ack)
  );

  trip_decide u_dec (
    .id_bit  (id_q),
    .cmp_bit (cmp_now),
    .pref    (pref_q),
    .abort   (abort_now),
    .dir     (dir_now),
    .code    (code_now)
  );

  trip_result u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_abort  (ev_abort),
    .ev_wr_ack (ev_wr_ack),
    .code      (code_now),
    .status    (status),
    .done      (done)
  );
endmodule

// File: rtl/trip_search_step_chk.sv
module trip_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       slot_req,
  input logic       slot_kind,
  input logic       slot_wbit,
  input logic       slot_ack,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic       ev_abort,
  input logic       ev_wr_ack
);
  // Input contract: the engine acknowledges only a pending request (R3).
  p_ack_contract_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ack |-> slot_req);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_kind) && $stable(slot_wbit)));

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && status == 3'b000));

  p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[0] && status[1]) |-> !status[2]);

  p_abort_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (done && status == 3'b011 && !slot_req));

  p_wr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ack |=> (done && !busy && status[2] == $past(slot_wbit)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> (done || busy));
endmodule

bind trip_search_step trip_search_step_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .slot_req  (slot_req),
  .slot_kind (slot_kind),
  .slot_wbit (slot_wbit),
  .slot_ack  (slot_ack),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .ev_abort  (ev_abort),
  .ev_wr_ack (ev_wr_ack)
);

// File: tb/trip_search_step_tb.sv
module trip_search_step_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pref_dir = 1'b0;
  logic       slot_ack = 1'b0;
  logic       slot_rbit = 1'b0;
  logic       slot_req, slot_kind, slot_wbit, busy, done;
  logic [2:0] status;

  int n_chk = 0;
  int n_bad = 0;
  logic stray_start = 1'b0;

  always #2.5 clk = ~clk;

  trip_search_step u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .slot_req(slot_req), .slot_kind(slot_kind), .slot_wbit(slot_wbit),
    .slot_ack(slot_ack), .slot_rbit(slot_rbit), .busy(busy), .done(done),
    .status(status)
  );

  // Vector: [8]=addr bit [7]=complement [6]=preferred [5:3]=status
  //         [2]=write expected [1]=written bit
  localparam logic [8:0] VEC [8] = '{
    9'b000_000_1_0_0,
    9'b001_100_1_1_0,
    9'b010_010_1_0_0,
    9'b011_010_1_0_0,
    9'b100_101_1_1_0,
    9'b101_101_1_1_0,
    9'b110_011_0_0_0,
    9'b111_011_0_0_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One step with a bus engine model answering after dly extra cycles.
  task automatic run_step(input logic id, input logic cmp, input logic pref, input int dly,
                          input logic flip_pref,
                          output logic [2:0] st, output int nrd, output int nwr,
                          output logic wb, output int order_bad, output logic got);
    int w;
    @(negedge clk);
    start = 1'b1; pref_dir = pref;
    @(negedge clk);
    start = 1'b0;
    if (flip_pref) pref_dir = ~pref;
    check("R2 busy after start", busy, 1);
    check("R2 status cleared", status, 0);
    nrd = 0; nwr = 0; wb = 1'b0; order_bad = 0; got = 1'b0; w = 0; st = 3'b000;
    for (int i = 0; i < 100; i++) begin
      if (i != 0) @(negedge clk);
      slot_ack = 1'b0;
      start = stray_start && (i % 2 == 1);
      if (done) begin got = 1'b1; st = status; break; end
      if (slot_req) begin
        if (w < dly) w++;
        else begin
          w = 0;
          slot_ack = 1'b1;
          if (slot_kind == 1'b0) begin
            if (nwr != 0) order_bad++;
            slot_rbit = (nrd == 0) ? id : cmp;
            nrd++;
          end else begin
            if (nrd != 2) order_bad++;
            wb = slot_wbit;
            slot_rbit = 1'b0;
            nwr++;
          end
        end
      end
    end
    start = 1'b0;
  endtask

  initial begin
    logic [2:0] st;
    int nrd, nwr, ob;
    logic wb, got;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 status in reset", status, 0);
    check("R1 done in reset", done, 0);
    check("R1 req in reset", slot_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 req after reset", slot_req, 0);

    // Table walk: R3..R8, R11 (preferred bit flipped after start)
    for (int v = 0; v < 8; v++) begin
      run_step(VEC[v][8], VEC[v][7], VEC[v][6], v % 3, 1'b1, st, nrd, nwr, wb, ob, got);
      check("R9 step completed", got, 1);
      check("R4 R6 R7 R11 status", st, VEC[v][5:3]);
      check("R3 two reads", nrd, 2);
      check("R5 R8 write count", nwr, VEC[v][2]);
      check("R3 R8 slot order", ob, 0);
      if (VEC[v][2]) check("R6 R7 R11 written bit", wb, VEC[v][1]);
      @(negedge clk);
      check("R9 done one cycle", done, 0);
      check("R8 idle after done", busy, 0);
    end

    // R9: status held after done while idle, pref_dir toggling
    run_step(1'b0, 1'b0, 1'b1, 0, 1'b0, st, nrd, nwr, wb, ob, got);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pref_dir = ~pref_dir;
      check("R9 status held", status, 3'b100);
      check("R9 no request while idle", slot_req, 0);
    end

    // R10: stray start pulses during a step
    stray_start = 1'b1;
    run_step(1'b1, 1'b0, 1'b0, 2, 1'b0, st, nrd, nwr, wb, ob, got);
    stray_start = 1'b0;
    check("R10 status", st, 3'b101);
    check("R10 reads", nrd, 2);
    check("R10 writes", nwr, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 no extra slot", slot_req, 0);
    end

    // R5: abort with a slow engine, then a fresh step still works
    run_step(1'b1, 1'b1, 1'b1, 2, 1'b0, st, nrd, nwr, wb, ob, got);
    check("R5 abort status", st, 3'b011);
    check("R5 no write", nwr, 0);
    run_step(1'b0, 1'b1, 1'b1, 1, 1'b0, st, nrd, nwr, wb, ob, got);
    check("R7 after abort", st, 3'b010);
    check("R7 write bit", wb, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule